// File: doc/BRIEF.md
# Decode-Stage Two-Bit Branch Predictor Table

This block holds a directly indexed table of conditional branch records. Each record keeps the word address of a branch, the word address it jumps to, and a two-bit saturating confidence counter. The decode stage resolves the branch in the same cycle it looks up the record. When a decoded branch presents its record number together with its two register operands and its branch control bit, the block works out the real outcome. It compares that outcome with the counter's prediction and, on a mismatch, drives a redirect address and a flush pulse to the fetch stage in that same cycle. At the next clock edge it moves the counter one step toward the real outcome.

Low counter values mean "taken". A branch goes taken when its control bit is set and the first operand is less than or equal to the second as signed two's-complement numbers. A load port writes a record's branch address and target and puts its counter back to the weakly-taken value. Which record a branch uses is chosen outside this block.

Top module: `bp_table`

## Requirements
- R1: After reset every counter holds 1 (weakly taken), so a not-taken branch on any record redirects once.
- R2: The real outcome is taken exactly when `br_ctl` is 1 and `opa` <= `opb` as signed two's-complement values. The outcome is not taken when `br_ctl` is 0.
- R3: Counter values 0 and 1 predict taken. Counter values 2 and 3 predict not taken.
- R4: A taken branch that was predicted not taken drives `redir_valid`=1 and `flush`=1 in the same cycle, with `redir_addr` set to the record's stored target.
- R5: A not-taken branch that was predicted taken drives `redir_valid`=1 and `flush`=1 in the same cycle, with `redir_addr` set to the record's branch address plus one, modulo 2^ADDR_W.
- R6: A correct prediction gives `redir_valid`=0 and `flush`=0. `redir_addr` is 0 whenever `redir_valid` is 0.
- R7: At the clock edge that ends a resolve cycle, the record's counter steps down by one if the branch was taken and stays at 0 if already 0. It steps up by one if the branch was not taken and stays at 3 if already 3.
- R8: While `res_valid` is 0 the block drives no redirect and no flush, and no counter changes.
- R9: A load writes the branch address and target into the record at `fill_idx` and sets that record's counter to 1 at the clock edge. If a resolve hits the same record in the same cycle, the resolve uses the old contents, and the load's values are what the record holds afterwards.
- R10: `flush` equals `redir_valid` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Load a record this cycle |
| fill_idx | input | IDX_W (4) | Record number to load |
| fill_pc | input | ADDR_W (16) | Branch word address to store |
| fill_tgt | input | ADDR_W (16) | Taken target word address to store |
| res_valid | input | 1 | A branch is resolving in decode this cycle |
| res_idx | input | IDX_W (4) | Record number of the resolving branch |
| br_ctl | input | 1 | Branch control bit from decode |
| opa | input | DATA_W (32) | First register operand |
| opb | input | DATA_W (32) | Second register operand |
| redir_valid | output | 1 | Fetch must be redirected |
| redir_addr | output | ADDR_W (16) | Redirect word address, 0 when idle |
| flush | output | 1 | Squash the wrongly fetched instruction |

## Verification
A record can be loaded and resolved in the same cycle, and the load and the counter update then compete for one counter. The bench provokes this by loading a record that is mid-training while a branch on that record resolves. It checks that the redirect in that cycle comes from the old address, target and counter. It then checks that the next resolve on the record behaves as if the counter were 1 and the new address and target were stored. A random phase repeats such collisions often by restricting record numbers to a small range, and a behavioural model compares all three outputs every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] bp_state_t;

  localparam bp_state_t ST_STRONG_T = 2'd0;
  localparam bp_state_t ST_WEAK_T   = 2'd1;
  localparam bp_state_t ST_WEAK_N   = 2'd2;
  localparam bp_state_t ST_STRONG_N = 2'd3;

  // Low half of the counter range predicts taken.
  function automatic logic predicts_taken(input bp_state_t s);
    return (s == ST_STRONG_T) || (s == ST_WEAK_T);
  endfunction

  // Saturating move toward the resolved direction.
  function automatic bp_state_t train(input bp_state_t s, input logic taken);
    bp_state_t n;
    if (taken) n = (s == ST_STRONG_T) ? ST_STRONG_T : bp_state_t'(s - 2'd1);
    else       n = (s == ST_STRONG_N) ? ST_STRONG_N : bp_state_t'(s + 2'd1);
    return n;
  endfunction

endpackage

// File: rtl/bp_outcome.sv
module bp_outcome #(
  parameter int DATA_W = 32
) (
  input  logic              br_ctl,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              taken
);

  logic le_s;

  always_comb begin
    le_s  = ($signed(opa) <= $signed(opb));
    taken = br_ctl & le_s;
  end

endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_pc,
  input  logic [ADDR_W-1:0] fill_tgt,
  input  logic              upd_en,
  input  logic              taken,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] tgt_q,
  output bp_state_t         st_q
);

  bp_state_t st_d;

  always_comb begin
    st_d = st_q;
    if (fill_en)     st_d = ST_WEAK_T;
    else if (upd_en) st_d = train(st_q, taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      tgt_q <= '0;
      st_q  <= ST_WEAK_T;
    end else begin
      if (fill_en) begin
        pc_q  <= fill_pc;
        tgt_q <= fill_tgt;
      end
      st_q <= st_d;
    end
  end

  // R8
  property p_idle_hold;
    @(posedge clk) disable iff (!rst_n)
      (!upd_en && !fill_en) |=> (st_q == $past(st_q));
  endproperty
  idle_hold_chk: assert property (p_idle_hold);

  // R7
  property p_moves_or_saturates;
    @(posedge clk) disable iff (!rst_n)
      (upd_en && !fill_en) |=> ((st_q != $past(st_q)) ||
                                ($past(taken) && $past(st_q) == ST_STRONG_T) ||
                                (!$past(taken) && $past(st_q) == ST_STRONG_N));
  endproperty
  train_step_chk: assert property (p_moves_or_saturates);

  // R9
  property p_fill_wins;
    @(posedge clk) disable iff (!rst_n)
      fill_en |=> (st_q == ST_WEAK_T && pc_q == $past(fill_pc) && tgt_q == $past(fill_tgt));
  endproperty
  fill_wins_chk: assert property (p_fill_wins);

endmodule

// File: rtl/bp_redirect.sv
module bp_redirect
  import bp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              resolve,
  input  logic              taken,
  input  bp_state_t         st,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] br_tgt,
  output logic              pred_taken,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr
);

  logic              mispredict;
  logic [ADDR_W-1:0] fallthru;

  always_comb begin
    pred_taken  = predicts_taken(st);
    mispredict  = resolve && (taken != pred_taken);
    fallthru    = br_pc + ADDR_W'(1);
    redir_valid = mispredict;
    redir_addr  = '0;
    if (mispredict) redir_addr = taken ? br_tgt : fallthru;
  end

endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [ADDR_W-1:0] fill_pc,
  input  logic [ADDR_W-1:0] fill_tgt,
  input  logic              res_valid,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic              br_ctl,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              flush
);

  logic [ADDR_W-1:0] ent_pc  [ENTRIES];
  logic [ADDR_W-1:0] ent_tgt [ENTRIES];
  bp_state_t         ent_st  [ENTRIES];

  logic              act_taken;
  logic              pred_taken;
  logic [ADDR_W-1:0] sel_pc;
  logic [ADDR_W-1:0] sel_tgt;
  bp_state_t         sel_st;

  bp_outcome #(.DATA_W(DATA_W)) u_outcome (
    .br_ctl (br_ctl),
    .opa    (opa),
    .opb    (opb),
    .taken  (act_taken)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit_fill;
    logic hit_res;
    assign hit_fill = fill_en   && (fill_idx == IDX_W'(g));
    assign hit_res  = res_valid && (res_idx  == IDX_W'(g));

    bp_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (hit_fill),
      .fill_pc  (fill_pc),
      .fill_tgt (fill_tgt),
      .upd_en   (hit_res),
      .taken    (act_taken),
      .pc_q     (ent_pc[g]),
      .tgt_q    (ent_tgt[g]),
      .st_q     (ent_st[g])
    );
  end

  always_comb begin
    sel_pc  = ent_pc[res_idx];
    sel_tgt = ent_tgt[res_idx];
    sel_st  = ent_st[res_idx];
  end

  bp_redirect #(.ADDR_W(ADDR_W)) u_redirect (
    .resolve     (res_valid),
    .taken       (act_taken),
    .st          (sel_st),
    .br_pc       (sel_pc),
    .br_tgt      (sel_tgt),
    .pred_taken  (pred_taken),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr)
  );

  assign flush = redir_valid;

  // R8
  property p_idle_quiet;
    @(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!redir_valid && !flush && redir_addr == '0);
  endproperty
  idle_quiet_chk: assert property (p_idle_quiet);

  // R3
  property p_pred_map;
    @(posedge clk) disable iff (!rst_n)
      res_valid |-> (pred_taken == (sel_st < 2'd2));
  endproperty
  pred_map_chk: assert property (p_pred_map);

  // R6
  property p_redirect_iff_miss;
    @(posedge clk) disable iff (!rst_n)
      res_valid |-> (redir_valid == (act_taken != pred_taken));
  endproperty
  redirect_iff_miss_chk: assert property (p_redirect_iff_miss);

  // R4
  property p_taken_target;
    @(posedge clk) disable iff (!rst_n)
      (redir_valid && act_taken) |-> (redir_addr == sel_tgt);
  endproperty
  taken_target_chk: assert property (p_taken_target);

  // R2
  property p_ctl_gate;
    @(posedge clk) disable iff (!rst_n)
      !br_ctl |-> !act_taken;
  endproperty
  ctl_gate_chk: assert property (p_ctl_gate);

endmodule

// File: tb/bp_table_tb.sv
module bp_table_tb;

  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fill_en = 1'b0;
  logic [IDX_W-1:0]  fill_idx = '0;
  logic [ADDR_W-1:0] fill_pc = '0;
  logic [ADDR_W-1:0] fill_tgt = '0;
  logic              res_valid = 1'b0;
  logic [IDX_W-1:0]  res_idx = '0;
  logic              br_ctl = 1'b0;
  logic [DATA_W-1:0] opa = '0;
  logic [DATA_W-1:0] opb = '0;
  logic              redir_valid;
  logic [ADDR_W-1:0] redir_addr;
  logic              flush;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // behavioural model
  int m_pc  [ENTRIES];
  int m_tgt [ENTRIES];
  int m_st  [ENTRIES];

  always #2 clk = ~clk;

  bp_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_pc(fill_pc), .fill_tgt(fill_tgt),
    .res_valid(res_valid), .res_idx(res_idx), .br_ctl(br_ctl), .opa(opa), .opb(opb),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .flush(flush)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare before posedge, update model after it.
  task automatic step(string tag, bit fe, int fi, int fp, int ft,
                      bit rv, int ri, bit ctl, int a, int b);
    bit tk, pt, ev;
    int ea, nst;
    fill_en = fe; fill_idx = IDX_W'(fi); fill_pc = ADDR_W'(fp); fill_tgt = ADDR_W'(ft);
    res_valid = rv; res_idx = IDX_W'(ri); br_ctl = ctl; opa = a; opb = b;
    #1;
    tk = ctl && (a <= b);
    pt = (m_st[ri] <= 1);
    ev = rv && (tk != pt);
    ea = 0;
    if (ev) ea = tk ? m_tgt[ri] : ((m_pc[ri] + 1) % 65536);
    check(tag, "redir_valid", int'(redir_valid), int'(ev));
    check(tag, "redir_addr", int'(redir_addr), ea);
    check("R10", "flush", int'(flush), int'(ev));
    nst = m_st[ri];
    if (tk) nst = (nst > 0) ? nst - 1 : 0;
    else    nst = (nst < 3) ? nst + 1 : 3;
    @(posedge clk);
    if (rv) m_st[ri] = nst;
    if (fe) begin
      m_pc[fi] = fp; m_tgt[fi] = ft; m_st[fi] = 1;
    end
    @(negedge clk);
  endtask

  task automatic resolve(string tag, int ri, bit ctl, int a, int b);
    step(tag, 0, 0, 0, 0, 1, ri, ctl, a, b);
  endtask

  task automatic load(int fi, int fp, int ft);
    step("R9", 1, fi, fp, ft, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_pc[i] = 0; m_tgt[i] = 0; m_st[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: idle after reset, outputs quiet
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 5);
    // R1: fresh counter predicts taken; not-taken branch redirects to 0+1
    resolve("R1", 0, 0, 0, 0);
    resolve("R1", 7, 1, 9, 2);

    load(3, 100, 40);
    load(5, 16'hFFFF, 1234);
    // R5 then R7: not taken drives 1->2->3->3
    resolve("R5", 3, 1, 10, 2);
    resolve("R6", 3, 1, 10, 2);
    resolve("R7", 3, 1, 10, 2);
    resolve("R7", 3, 0, 1, 2);
    // R4: taken from 3 and 2 redirects to target; R3 at 1 predicts taken
    resolve("R4", 3, 1, 4, 4);
    resolve("R4", 3, 1, 4, 4);
    resolve("R3", 3, 1, 4, 4);
    resolve("R7", 3, 1, 4, 4);
    resolve("R3", 3, 1, 4, 4);
    // R2: signed compare, -1 <= 1 is taken; 1 <= -1 is not
    resolve("R2", 3, 1, -1, 1);
    resolve("R2", 3, 1, 1, -1);
    resolve("R2", 3, 1, 32'sh80000000, 32'sh7FFFFFFF);
    // R5 wrap: address FFFF + 1 gives 0
    resolve("R5", 5, 1, 3, -3);
    // R8: invalid cycles do not train; next resolve still sees state 2
    step("R8", 0, 0, 0, 0, 0, 5, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 5, 1, 0, 0);
    resolve("R8", 5, 1, 0, 0);
    // R9: load collides with resolve on the same record
    resolve("R9", 3, 1, 8, 1);
    resolve("R9", 3, 1, 8, 1);
    step("R9", 1, 3, 500, 600, 1, 3, 1, 0, 0);
    resolve("R9", 3, 0, 0, 0);
    resolve("R9", 3, 1, 0, 0);

    // random mix with frequent collisions
    for (int k = 0; k < 600; k++) begin
      bit fe, rv, ctl;
      int fi, ri, a, b;
      fe  = ($urandom_range(0, 5) == 0);
      rv  = ($urandom_range(0, 4) != 0);
      ctl = ($urandom_range(0, 5) != 0);
      ri  = (k < 300) ? $urandom_range(0, 2) : $urandom_range(0, ENTRIES - 1);
      fi  = $urandom_range(0, 1) ? ri : $urandom_range(0, ENTRIES - 1);
      a   = $urandom_range(0, 3) == 0 ? int'($urandom) : $urandom_range(0, 20) - 10;
      b   = $urandom_range(0, 3) == 0 ? int'($urandom) : $urandom_range(0, 20) - 10;
      step(rv ? "R7" : "R8", fe, fi, $urandom_range(0, 65535), $urandom_range(0, 65535),
           rv, ri, ctl, a, b);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule